// File: doc/BRIEF.md
# Smart Card Channel Fault Supervisor

This block supervises the electrical state of one or two smart card channels. A channel is armed once its two-bit supply voltage setting is non-zero. While armed, the block watches comparator flags for a sagging supply and for excess current. It compares the driven clock and reset pins against the levels they are meant to carry. It also tracks whether the card is still in the socket and watches a chip-wide overtemperature flag.

A condition that persists is latched as a fault bit on its channel. On the cycle that bit first sets, the block sends a one-cycle deactivate request to the power sequencer of that channel. An OR of all fault bits drives the enable of an open-drain, active-low interrupt pin. Software clears a channel's fault by writing a zero supply setting, which also disarms the channel. Card I/O line shorts are not watched here.

Top module: `smartcard_fault_sup`

## Requirements
- R1: After reset, every fault bit, every deactivate pulse and the interrupt enable are 0.
- R2: A supply-low flag that is high on TIMEOUT consecutive sampled edges of an armed channel sets that channel's fault at the last of those edges. A single low sample restarts the count.
- R3: An overcurrent flag obeys the same TIMEOUT consecutive-sample rule as R2.
- R4: A reset pin that differs from its expected level obeys the same TIMEOUT consecutive-sample rule as R2.
- R5: Clock pin mismatches are accumulated. The fault sets on the edge that samples the CLK_LIMIT-th mismatch since the channel was armed. Matching samples in between do not reduce the count.
- R6: An overtemperature flag high for TIMEOUT consecutive edges sets the fault of every armed channel at once.
- R7: Card removal faults an armed channel on the next edge, with no timeout. With the polarity select at 0, a high presence input means the card is gone. With the select at 1, a low presence input means the card is gone.
- R8: Changing a channel's voltage setting from 00 to non-zero while its card is absent faults that channel on the first edge.
- R9: A fault bit stays set while the channel's setting stays non-zero. A setting of 00 clears the fault at the next edge and also empties the channel's clock mismatch accumulator.
- R10: No fault and no deactivate pulse can appear on a channel whose setting is 00, whatever its inputs.
- R11: The deactivate output of a channel is high for exactly one cycle, the cycle its fault bit first reads 1.
- R12: The interrupt enable `fault_oe_o` is 1 exactly when at least one fault bit is 1.

Channel i uses `vsel_i[2i+1:2i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsel_i | input | 2*NCH | Per-channel supply setting, 00 = off |
| vlow_i | input | NCH | Supply-low comparator flags |
| ovc_i | input | NCH | Overcurrent comparator flags |
| clk_pin_i | input | NCH | Observed card clock pin levels |
| clk_exp_i | input | NCH | Expected card clock levels |
| rst_pin_i | input | NCH | Observed card reset pin levels |
| rst_exp_i | input | NCH | Expected card reset levels |
| present_i | input | NCH | Card presence inputs |
| pres_pol_i | input | 1 | Presence polarity select |
| otemp_i | input | 1 | Shared overtemperature flag |
| fault_o | output | NCH | Latched fault bit per channel |
| deact_o | output | NCH | One-cycle deactivate request per channel |
| fault_oe_o | output | 1 | Pull-down enable for the shared interrupt pin |

## Verification
The bench targets the off-by-one at the persistence limit by checking one edge before and at the limit. A counter that stops one cycle early or late fails there. An alternating clock mismatch pattern is used next: a clock check that resets on good samples would never fault on it. Overtemperature is raised with one channel disarmed, so a design that forced both fault bits would be caught. The bench also drives card removal under both polarity settings and powers up into an empty socket. Re-arming after a power-down then has to show a fresh clock accumulator, and a random phase compares every cycle against a bench model.

// File: rtl/scf_pkg.sv
package scf_pkg;

   typedef logic [1:0] vsel_t;

   localparam vsel_t VSEL_OFF = 2'b00;

   // card absent decode: pol 0 -> high input means gone, pol 1 -> low input means gone
   function automatic logic card_gone(input logic pres, input logic pol);
      return pol ? ~pres : pres;
   endfunction

endpackage

// File: rtl/scf_persist.sv
module scf_persist #(
   parameter int LIMIT = 1024,
   parameter bit ACCUM = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic cond,
   output logic hit
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("scf_persist: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_d;
   logic          at_top;

   assign at_top = (cnt_q == TOP);
   assign hit    = cond & at_top;

   generate
      if (ACCUM) begin : g_accum
         // errors pile up, good samples leave the count alone
         always_comb begin
            cnt_d = cnt_q;
            if (cond && !at_top) cnt_d = cnt_q + 1'b1;
         end
      end else begin : g_run
         // consecutive run: a good sample restarts
         always_comb begin
            if (!cond)        cnt_d = '0;
            else if (!at_top) cnt_d = cnt_q + 1'b1;
            else              cnt_d = cnt_q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_d;
   end
endmodule

// File: rtl/scf_channel.sv
module scf_channel
   import scf_pkg::*;
#(
   parameter int TIMEOUT   = 1024,
   parameter int CLK_LIMIT = 4096
) (
   input  logic  clk,
   input  logic  rst_n,
   input  vsel_t vsel,
   input  logic  vlow,
   input  logic  ovc,
   input  logic  clk_pin,
   input  logic  clk_exp,
   input  logic  rst_pin,
   input  logic  rst_exp,
   input  logic  present,
   input  logic  pres_pol,
   input  logic  ot_hit,
   output logic  fault,
   output logic  deact
);
   logic powered;
   logic gone;
   logic hit_vlow, hit_ovc, hit_rst, hit_clk;
   logic set_now;
   logic fault_q, deact_q;

   assign powered = (vsel != VSEL_OFF);
   assign gone    = card_gone(present, pres_pol);

   scf_persist #(.LIMIT(TIMEOUT), .ACCUM(1'b0)) u_vlow (
      .clk(clk), .rst_n(rst_n), .clr(~powered), .cond(vlow), .hit(hit_vlow));

   scf_persist #(.LIMIT(TIMEOUT), .ACCUM(1'b0)) u_ovc (
      .clk(clk), .rst_n(rst_n), .clr(~powered), .cond(ovc), .hit(hit_ovc));

   scf_persist #(.LIMIT(TIMEOUT), .ACCUM(1'b0)) u_rst (
      .clk(clk), .rst_n(rst_n), .clr(~powered), .cond(rst_pin ^ rst_exp), .hit(hit_rst));

   scf_persist #(.LIMIT(CLK_LIMIT), .ACCUM(1'b1)) u_clk (
      .clk(clk), .rst_n(rst_n), .clr(~powered), .cond(clk_pin ^ clk_exp), .hit(hit_clk));

   assign set_now = powered & (hit_vlow | hit_ovc | hit_rst | hit_clk | gone | ot_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
         deact_q <= 1'b0;
      end else if (!powered) begin
         fault_q <= 1'b0;
         deact_q <= 1'b0;
      end else begin
         fault_q <= fault_q | set_now;
         deact_q <= set_now & ~fault_q;
      end
   end

   assign fault = fault_q;
   assign deact = deact_q;
endmodule

// File: rtl/smartcard_fault_sup.sv
module smartcard_fault_sup
   import scf_pkg::*;
#(
   parameter int NCH       = 2,
   parameter int TIMEOUT   = 1024,
   parameter int CLK_LIMIT = 4096
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2*NCH-1:0] vsel_i,
   input  logic [NCH-1:0]   vlow_i,
   input  logic [NCH-1:0]   ovc_i,
   input  logic [NCH-1:0]   clk_pin_i,
   input  logic [NCH-1:0]   clk_exp_i,
   input  logic [NCH-1:0]   rst_pin_i,
   input  logic [NCH-1:0]   rst_exp_i,
   input  logic [NCH-1:0]   present_i,
   input  logic             pres_pol_i,
   input  logic             otemp_i,
   output logic [NCH-1:0]   fault_o,
   output logic [NCH-1:0]   deact_o,
   output logic             fault_oe_o
);
   generate
      if (NCH < 1 || NCH > 2) begin : g_bad_nch
         $error("smartcard_fault_sup: NCH must be 1 or 2");
      end
      if (CLK_LIMIT < TIMEOUT) begin : g_bad_window
         $error("smartcard_fault_sup: CLK_LIMIT must not be shorter than TIMEOUT");
      end
   endgenerate

   logic ot_hit;

   scf_persist #(.LIMIT(TIMEOUT), .ACCUM(1'b0)) u_otemp (
      .clk(clk), .rst_n(rst_n), .clr(1'b0), .cond(otemp_i), .hit(ot_hit));

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         scf_channel #(.TIMEOUT(TIMEOUT), .CLK_LIMIT(CLK_LIMIT)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .vsel     (vsel_i[2*c +: 2]),
            .vlow     (vlow_i[c]),
            .ovc      (ovc_i[c]),
            .clk_pin  (clk_pin_i[c]),
            .clk_exp  (clk_exp_i[c]),
            .rst_pin  (rst_pin_i[c]),
            .rst_exp  (rst_exp_i[c]),
            .present  (present_i[c]),
            .pres_pol (pres_pol_i),
            .ot_hit   (ot_hit),
            .fault    (fault_o[c]),
            .deact    (deact_o[c])
         );
      end
   endgenerate

   assign fault_oe_o = |fault_o;
endmodule

// File: rtl/scf_chk.sv
module scf_chk #(
   parameter int NCH = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2*NCH-1:0] vsel_i,
   input logic [NCH-1:0]   present_i,
   input logic             pres_pol_i,
   input logic [NCH-1:0]   fault_o,
   input logic [NCH-1:0]   deact_o,
   input logic             fault_oe_o
);
   for (genvar c = 0; c < NCH; c++) begin : g_c
      // R11
      deact_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         deact_o[c] |-> (fault_o[c] && !$past(fault_o[c])));
      // R11
      deact_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(fault_o[c]) |-> deact_o[c]);
      // R9
      sticky_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (fault_o[c] && vsel_i[2*c +: 2] != 2'b00) |=> fault_o[c]);
      // R10
      off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (vsel_i[2*c +: 2] == 2'b00) |=> (!fault_o[c] && !deact_o[c]));
      // R7
      removal_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (vsel_i[2*c +: 2] != 2'b00 && (pres_pol_i ? !present_i[c] : present_i[c]))
         |=> fault_o[c]);
   end

   // R12
   oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_oe_o) |-> (deact_o != '0));
endmodule

bind smartcard_fault_sup scf_chk #(.NCH(NCH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .vsel_i     (vsel_i),
   .present_i  (present_i),
   .pres_pol_i (pres_pol_i),
   .fault_o    (fault_o),
   .deact_o    (deact_o),
   .fault_oe_o (fault_oe_o)
);

// File: tb/smartcard_fault_sup_test.sv
`timescale 1ns/1ps
module smartcard_fault_sup_test;
   localparam int T = 16;
   localparam int L = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] vsel = '0;
   logic [1:0] vlow = '0, ovc = '0, clkp = '0, clke = '0, rstp = '0, rste = '0, pres = '0;
   logic       pol = 1'b0, otemp = 1'b0;
   logic [1:0] fault, deact;
   logic       oe;

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;
   bit  model_on = 0;

   always #4 clk = ~clk;

   smartcard_fault_sup #(.NCH(2), .TIMEOUT(T), .CLK_LIMIT(L)) uut (
      .clk(clk), .rst_n(rst_n), .vsel_i(vsel), .vlow_i(vlow), .ovc_i(ovc),
      .clk_pin_i(clkp), .clk_exp_i(clke), .rst_pin_i(rstp), .rst_exp_i(rste),
      .present_i(pres), .pres_pol_i(pol), .otemp_i(otemp),
      .fault_o(fault), .deact_o(deact), .fault_oe_o(oe));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   // bench reference model, built from the requirements
   int mv[2], mo[2], mr[2], mc[2], mot;
   bit mf[2], md[2];

   function automatic bit adv(input bit c, inout int n, input int lim, input bit acc);
      bit h;
      h = c && (n == lim - 1);
      if (c) begin
         if (n != lim - 1) n++;
      end else if (!acc) n = 0;
      return h;
   endfunction

   always @(posedge clk) begin
      if (model_on) begin
         bit oth;
         oth = adv(otemp, mot, T, 1'b0);
         for (int c = 0; c < 2; c++) begin
            bit pw, ab, s;
            pw = vsel[2*c +: 2] != 2'b00;
            ab = pol ? !pres[c] : pres[c];
            if (!pw) begin
               mv[c] = 0; mo[c] = 0; mr[c] = 0; mc[c] = 0; mf[c] = 0; md[c] = 0;
            end else begin
               s = 0;
               s |= adv(vlow[c], mv[c], T, 1'b0);
               s |= adv(ovc[c], mo[c], T, 1'b0);
               s |= adv(rstp[c] ^ rste[c], mr[c], T, 1'b0);
               s |= adv(clkp[c] ^ clke[c], mc[c], L, 1'b1);
               s |= ab | oth;
               md[c] = s && !mf[c];
               mf[c] = mf[c] | s;
            end
         end
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      ticks(3);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 fault", fault, 0);
      chk("R1 deact", deact, 0);
      chk("R1 oe", oe, 0);

      // R2 supply-low persistence with a restart
      vsel[1:0] = 2'b01; tick();
      vlow[0] = 1; ticks(T - 1);
      chk("R2 below limit", fault, 0);
      vlow[0] = 0; tick();
      vlow[0] = 1; ticks(T - 1);
      chk("R2 restart", fault, 0);
      tick();
      chk("R2 fault", fault, 2'b01);
      chk("R11 deact pulse", deact, 2'b01);
      chk("R12 oe on", oe, 1);
      tick();
      chk("R11 deact single", deact, 0);
      vlow[0] = 0; ticks(3);
      chk("R9 sticky", fault, 2'b01);
      vsel[1:0] = 2'b00; tick();
      chk("R9 cleared", fault, 0);
      chk("R12 oe off", oe, 0);
      vlow[0] = 1; ticks(2 * T);
      chk("R10 off no fault", fault, 0);
      chk("R10 off no deact", deact, 0);
      vlow[0] = 0;

      // R3 overcurrent on channel 1
      vsel[3:2] = 2'b10; tick();
      ovc[1] = 1; ticks(T - 1);
      chk("R3 below limit", fault, 0);
      tick();
      chk("R3 fault", fault, 2'b10);
      chk("R11 deact ch1", deact, 2'b10);
      ovc[1] = 0; vsel[3:2] = 2'b00; tick();

      // R5 clock accumulation with alternating errors
      vsel[1:0] = 2'b11; tick();
      clke[0] = 0;
      for (int k = 0; k < 2 * L - 2; k++) begin
         clkp[0] = (k % 2 == 0);
         tick();
      end
      chk("R5 one short", fault, 0);
      clkp[0] = 1; tick();
      chk("R5 accumulated", fault, 2'b01);
      clkp[0] = 0;

      // R9 power-down empties the accumulator
      vsel[1:0] = 2'b00; tick();
      vsel[1:0] = 2'b11; tick();
      chk("R9 rearm clear", fault, 0);
      clkp[0] = 1; ticks(L - 1);
      chk("R9 accum reset", fault, 0);
      tick();
      chk("R5 fresh limit", fault, 2'b01);
      clkp[0] = 0; vsel[1:0] = 2'b00; tick();

      // R4 reset-pin mismatch persistence
      vsel[1:0] = 2'b01; tick();
      rste[0] = 0; rstp[0] = 1; ticks(T - 1);
      rstp[0] = 0; tick();
      rstp[0] = 1; ticks(T - 1);
      chk("R4 below limit", fault, 0);
      tick();
      chk("R4 fault", fault, 2'b01);
      rstp[0] = 0; vsel[1:0] = 2'b00; tick();

      // R6 overtemperature, one channel disarmed then both armed
      vsel = 4'b0001; tick();
      otemp = 1; ticks(T - 1);
      chk("R6 below limit", fault, 0);
      tick();
      chk("R6 armed only", fault, 2'b01);
      chk("R6 deact armed only", deact, 2'b01);
      otemp = 0; vsel = 4'b0000; tick();
      vsel = 4'b0101; tick();
      otemp = 1; ticks(T);
      chk("R6 both", fault, 2'b11);
      chk("R6 deact both", deact, 2'b11);
      otemp = 0; vsel = 4'b0000; tick();

      // R7 card removal, both polarities
      vsel[3:2] = 2'b01; tick();
      pres[1] = 1; tick();
      chk("R7 removal pol0", fault, 2'b10);
      chk("R7 deact", deact, 2'b10);
      pres = 2'b00; vsel = 4'b0000; tick();
      pol = 1; pres = 2'b11; vsel[3:2] = 2'b01; tick();
      chk("R7 present pol1", fault, 0);
      pres[1] = 0; tick();
      chk("R7 removal pol1", fault, 2'b10);
      vsel = 4'b0000; pol = 0; pres = 2'b00; tick();

      // R8 power up into an empty socket
      pres[0] = 1; ticks(2);
      chk("R10 empty off", fault, 0);
      vsel[1:0] = 2'b10; tick();
      chk("R8 power-up fault", fault, 2'b01);
      chk("R8 deact", deact, 2'b01);
      vsel = 4'b0000; pres = 2'b00; tick();

      // random phase against the model
      vsel = '0; otemp = 0; vlow = '0; ovc = '0; clkp = '0; clke = '0;
      rstp = '0; rste = '0; pres = '0; pol = 0;
      ticks(2);
      for (int c = 0; c < 2; c++) begin
         mv[c] = 0; mo[c] = 0; mr[c] = 0; mc[c] = 0; mf[c] = 0; md[c] = 0;
      end
      mot = 0;
      model_on = 1;
      for (int n = 0; n < 4000; n++) begin
         for (int c = 0; c < 2; c++) begin
            if ($urandom_range(0, 19) == 0) vlow[c] = ~vlow[c];
            if ($urandom_range(0, 19) == 0) ovc[c] = ~ovc[c];
            if ($urandom_range(0, 19) == 0) rstp[c] = ~rstp[c];
            if ($urandom_range(0, 9) == 0) rste[c] = ~rste[c];
            clke[c] = ~clke[c];
            clkp[c] = ($urandom_range(0, 3) == 0) ? clke[c] : ~clke[c];
            if ($urandom_range(0, 299) == 0) pres[c] = ~pres[c];
            if ($urandom_range(0, 119) == 0) vsel[2*c +: 2] = 2'($urandom_range(0, 3));
         end
         if ($urandom_range(0, 99) == 0) otemp = ~otemp;
         if ($urandom_range(0, 999) == 0) pol = ~pol;
         tick();
         // R2 R5 R9 R11 model comparison
         chk("R2 model fault", fault, {mf[1], mf[0]});
         chk("R11 model deact", deact, {md[1], md[0]});
         chk("R12 model oe", oe, mf[0] | mf[1]);
      end
      model_on = 0;

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule